// File: doc/BRIEF.md
# Debug Register File

This block holds the processor's eight architectural debug registers and serves the read and write requests that an instruction decoder issues against them. Four address registers (indices 0 to 3) carry the linear addresses the breakpoint match units compare against. Index 6 is the status word and index 7 is the control word. Both words are exported continuously, along with the address registers, so the match logic always sees the committed state.

Indices 4 and 5 are legacy names. While the extension-enable input is low they act as aliases for 6 and 7. While it is high they are illegal, and any access to them produces an illegal-opcode indication instead of completing. A write to the status or control word that sets any reserved bit is refused with a general-protection indication. Every accepted write to those two words forces their fixed-one bits high. Each access is sampled on a clock edge, and its effects appear after that edge. The result of a read appears on the read-data port, and fault indications appear as one-cycle pulses.

Top module: `dbgrf_top`

## Requirements
- R1: After reset, the four address registers read 0, the status word is 0xFFFF_FFFF_FFFF_0FF0 masked to the low 32 bits (0x0000_0000_FFFF_0FF0), the control word is 0x0000_0000_0000_0400, the read data is 0, and neither fault flag is set.
- R2: A write to index 0, 1, 2 or 3 stores all 64 bits of the write data, upper half included, into that address register, with no check applied.
- R3: With the extension-enable input low, a read or write of index 4 acts exactly as index 6 (status), and index 5 acts exactly as index 7 (control).
- R4: With the extension-enable input high, a read or write of index 4 or 5 raises the illegal-opcode flag in the cycle after the request. No register changes and the read data keeps its previous value.
- R5: A write to the status or control word whose data has any bit in 63:32 set raises the general-protection flag in the cycle after the request. The error-code output is 0. No register changes, and a read requested in the same cycle does not update the read data.
- R6: An accepted status write stores the write data ORed with 0xFFFF0FF0.
- R7: An accepted control write stores the write data ORed with 0x00000400.
- R8: A read loads the selected register's value into the read data on the clock edge that samples the request. If a write is requested in the same cycle, the read returns the value held before that write.
- R9: Each fault flag is high for exactly the cycle after a faulting request. The two flags are never high together. A request that is both illegal and carries reserved bits reports only the illegal-opcode fault.
- R10: The extension-enable input has no effect on accesses to indices 0 to 3, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_i | input | 3 | Register index of the request |
| wr_en_i | input | 1 | Write request strobe |
| rd_en_i | input | 1 | Read request strobe |
| wdata_i | input | 64 | Write data |
| ext_en_i | input | 1 | Debug extension enable; makes indices 4 and 5 illegal |
| rdata_o | output | 64 | Value returned by the last completed read |
| ill_fault_o | output | 1 | Illegal-opcode fault pulse |
| gp_fault_o | output | 1 | General-protection fault pulse |
| gp_code_o | output | 16 | Error code accompanying a general-protection fault |
| status_o | output | 64 | Current status word |
| ctrl_o | output | 64 | Current control word |
| addr_flat_o | output | 256 | The four address registers, register 0 in the low bits |

## Verification
The bench aims at the alias boundary by hitting indices 4 and 5 with the extension input both low and high. A design that decoded the alias backwards would fault on legal requests, or would silently write the status word on illegal ones. Writes that carry a single reserved bit at bit 32 or bit 63 check that a refused write leaves the word untouched; a partial mask check would let those bits leak into the control word. Same-cycle read and write, and an illegal write that also carries reserved bits, expose a read that returns the new value or a fault priority that reports the wrong flag. Writes to the address registers with upper bits set catch a design that wrongly applies the reserved check to them.

// File: rtl/dbgrf_pkg.sv
package dbgrf_pkg;

    // Architectural index map; the alias relation below is behaviour.
    localparam int unsigned IDX_W        = 3;
    localparam int unsigned NUM_ADDR     = 4;
    localparam logic [IDX_W-1:0] IDX_LEG_STAT = 3'd4;
    localparam logic [IDX_W-1:0] IDX_LEG_CTRL = 3'd5;
    localparam logic [IDX_W-1:0] IDX_STAT     = 3'd6;
    localparam logic [IDX_W-1:0] IDX_CTRL     = 3'd7;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ADDR = 2'd1,
        TGT_STAT = 2'd2,
        TGT_CTRL = 2'd3
    } dbg_tgt_e;

    typedef enum logic [1:0] {
        OUT_OK   = 2'd0,
        OUT_ILL  = 2'd1,
        OUT_GP   = 2'd2
    } dbg_outcome_e;

endpackage

// File: rtl/dbgrf_decode.sv
module dbgrf_decode
    import dbgrf_pkg::*;
#(
    parameter int unsigned N_ADDR = NUM_ADDR,
    localparam int unsigned SEL_W = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             ext_en_i,
    output dbg_tgt_e         tgt_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             ill_o
);

    always_comb begin
        tgt_o = TGT_NONE;
        sel_o = idx_i[SEL_W-1:0];
        ill_o = 1'b0;
        if (idx_i < IDX_W'(N_ADDR)) begin
            tgt_o = TGT_ADDR;
        end else if (idx_i == IDX_LEG_STAT || idx_i == IDX_LEG_CTRL) begin
            if (ext_en_i) begin
                ill_o = 1'b1;
            end else begin
                tgt_o = (idx_i == IDX_LEG_STAT) ? TGT_STAT : TGT_CTRL;
            end
        end else if (idx_i == IDX_STAT) begin
            tgt_o = TGT_STAT;
        end else if (idx_i == IDX_CTRL) begin
            tgt_o = TGT_CTRL;
        end
    end

endmodule

// File: rtl/dbgrf_wrcheck.sv
module dbgrf_wrcheck
    import dbgrf_pkg::*;
#(
    parameter int unsigned     XLEN     = 64,
    parameter logic [XLEN-1:0] RSVD     = {{(XLEN/2){1'b1}}, {(XLEN/2){1'b0}}},
    parameter logic [XLEN-1:0] FIX_STAT = XLEN'(32'hFFFF0FF0),
    parameter logic [XLEN-1:0] FIX_CTRL = XLEN'(32'h00000400)
) (
    input  dbg_tgt_e        tgt_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic            rsvd_hit_o,
    output logic [XLEN-1:0] stat_val_o,
    output logic [XLEN-1:0] ctrl_val_o
);

    logic ctl_word;

    always_comb begin
        ctl_word   = (tgt_i == TGT_STAT) || (tgt_i == TGT_CTRL);
        rsvd_hit_o = ctl_word && ((wdata_i & RSVD) != '0);
        stat_val_o = wdata_i | FIX_STAT;
        ctrl_val_o = wdata_i | FIX_CTRL;
    end

endmodule

// File: rtl/dbgrf_top.sv
module dbgrf_top
    import dbgrf_pkg::*;
#(
    parameter int unsigned     XLEN     = 64,
    parameter int unsigned     N_ADDR   = NUM_ADDR,
    parameter int unsigned     CODE_W   = 16,
    parameter logic [XLEN-1:0] FIX_STAT = XLEN'(32'hFFFF0FF0),
    parameter logic [XLEN-1:0] FIX_CTRL = XLEN'(32'h00000400),
    localparam logic [XLEN-1:0] RSVD    = {{(XLEN/2){1'b1}}, {(XLEN/2){1'b0}}},
    localparam int unsigned    SEL_W    = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic                     wr_en_i,
    input  logic                     rd_en_i,
    input  logic [XLEN-1:0]          wdata_i,
    input  logic                     ext_en_i,
    output logic [XLEN-1:0]          rdata_o,
    output logic                     ill_fault_o,
    output logic                     gp_fault_o,
    output logic [CODE_W-1:0]        gp_code_o,
    output logic [XLEN-1:0]          status_o,
    output logic [XLEN-1:0]          ctrl_o,
    output logic [N_ADDR*XLEN-1:0]   addr_flat_o
);

    typedef struct packed {
        logic [N_ADDR-1:0][XLEN-1:0] addr;
        logic [XLEN-1:0]             stat;
        logic [XLEN-1:0]             ctrl;
        logic [XLEN-1:0]             rdata;
        logic                        ill;
        logic                        gp;
    } rf_state_t;

    rf_state_t    st_d, st_q;
    dbg_tgt_e     tgt;
    logic [SEL_W-1:0] sel;
    logic         dec_ill;
    logic         rsvd_hit;
    logic [XLEN-1:0] stat_val, ctrl_val;
    dbg_outcome_e outcome;
    logic         req;

    dbgrf_decode #(.N_ADDR(N_ADDR)) u_decode (
        .idx_i    (idx_i),
        .ext_en_i (ext_en_i),
        .tgt_o    (tgt),
        .sel_o    (sel),
        .ill_o    (dec_ill)
    );

    dbgrf_wrcheck #(
        .XLEN     (XLEN),
        .RSVD     (RSVD),
        .FIX_STAT (FIX_STAT),
        .FIX_CTRL (FIX_CTRL)
    ) u_wrcheck (
        .tgt_i      (tgt),
        .wdata_i    (wdata_i),
        .rsvd_hit_o (rsvd_hit),
        .stat_val_o (stat_val),
        .ctrl_val_o (ctrl_val)
    );

    // Outcome priority: illegal index beats reserved-bit check.
    always_comb begin
        req = wr_en_i | rd_en_i;
        if (req && dec_ill) begin
            outcome = OUT_ILL;
        end else if (wr_en_i && rsvd_hit) begin
            outcome = OUT_GP;
        end else begin
            outcome = OUT_OK;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.ill = (outcome == OUT_ILL);
        st_d.gp  = (outcome == OUT_GP);
        if (outcome == OUT_OK) begin
            if (rd_en_i) begin
                unique case (tgt)
                    TGT_ADDR: st_d.rdata = st_q.addr[sel];
                    TGT_STAT: st_d.rdata = st_q.stat;
                    TGT_CTRL: st_d.rdata = st_q.ctrl;
                    default:  st_d.rdata = st_q.rdata;
                endcase
            end
            if (wr_en_i) begin
                unique case (tgt)
                    TGT_ADDR: st_d.addr[sel] = wdata_i;
                    TGT_STAT: st_d.stat      = stat_val;
                    TGT_CTRL: st_d.ctrl      = ctrl_val;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr  <= '0;
            st_q.stat  <= FIX_STAT;
            st_q.ctrl  <= FIX_CTRL;
            st_q.rdata <= '0;
            st_q.ill   <= 1'b0;
            st_q.gp    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o     = st_q.rdata;
    assign ill_fault_o = st_q.ill;
    assign gp_fault_o  = st_q.gp;
    assign gp_code_o   = '0;
    assign status_o    = st_q.stat;
    assign ctrl_o      = st_q.ctrl;
    assign addr_flat_o = st_q.addr;

    // ---------------- assertions ----------------
    p_ill_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ill_fault_o |-> $past(ext_en_i && (rd_en_i || wr_en_i) &&
                              (idx_i == IDX_LEG_STAT || idx_i == IDX_LEG_CTRL)));

    p_ill_no_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ill_fault_o |-> ($stable(status_o) && $stable(ctrl_o) &&
                         $stable(addr_flat_o) && $stable(rdata_o)));

    p_gp_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault_o |-> $past(wr_en_i && ((wdata_i & RSVD) != '0)));

    p_gp_no_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault_o |-> ($stable(status_o) && $stable(ctrl_o) &&
                        $stable(addr_flat_o) && $stable(rdata_o)));

    p_stat_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & FIX_STAT) == FIX_STAT);

    p_ctrl_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_o & FIX_CTRL) == FIX_CTRL) && ((ctrl_o & RSVD) == '0));

    p_one_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ill_fault_o && gp_fault_o));

    p_ctrl_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> $stable(ctrl_o));

endmodule

// File: tb/dbgrf_top_test.sv
module dbgrf_top_test;

    localparam int XLEN = 64;
    localparam logic [63:0] FS = 64'h0000_0000_FFFF_0FF0;
    localparam logic [63:0] FC = 64'h0000_0000_0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  idx = '0;
    logic        wr = 1'b0, rd = 1'b0, ext = 1'b0;
    logic [63:0] wd = '0;
    logic [63:0] rdata, stat, ctrl;
    logic        ill, gp;
    logic [15:0] code;
    logic [255:0] aflat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] m_addr [4];
    logic [63:0] m_stat, m_ctrl, m_rd;
    logic        m_ill, m_gp;

    always #5 clk = ~clk;

    dbgrf_top uut (
        .clk(clk), .rst_n(rst_n), .idx_i(idx), .wr_en_i(wr), .rd_en_i(rd),
        .wdata_i(wd), .ext_en_i(ext), .rdata_o(rdata), .ill_fault_o(ill),
        .gp_fault_o(gp), .gp_code_o(code), .status_o(stat), .ctrl_o(ctrl),
        .addr_flat_o(aflat)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int resolve(input logic [2:0] i);
        if (i == 3'd4) return 6;
        if (i == 3'd5) return 7;
        return int'(i);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) m_addr[k] = '0;
        m_stat = FS; m_ctrl = FC; m_rd = '0; m_ill = 0; m_gp = 0;
    endtask

    task automatic model_step(input logic [2:0] i, input logic w, input logic r,
                              input logic [63:0] d, input logic e);
        int t;
        logic [63:0] v;
        t = resolve(i);
        m_ill = (w || r) && e && (i == 3'd4 || i == 3'd5);
        m_gp  = !m_ill && w && t >= 6 && (d[63:32] != 32'd0);
        if (!m_ill && !m_gp) begin
            if (r) begin
                v = (t < 4) ? m_addr[t] : (t == 6) ? m_stat : m_ctrl;
                m_rd = v;
            end
            if (w) begin
                if (t < 4) m_addr[t] = d;
                else if (t == 6) m_stat = d | FS;
                else m_ctrl = d | FC;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R4 ill"}, {63'd0, ill}, {63'd0, m_ill});
        chk({tag, " R5 gp"}, {63'd0, gp}, {63'd0, m_gp});
        if (gp) chk({tag, " R5 code"}, {48'd0, code}, 64'd0);
        chk({tag, " R8 rdata"}, rdata, m_rd);
        chk({tag, " R6 status"}, stat, m_stat);
        chk({tag, " R7 ctrl"}, ctrl, m_ctrl);
        for (int k = 0; k < 4; k++)
            chk({tag, " R2 addr"}, aflat[k*64 +: 64], m_addr[k]);
    endtask

    // Drive on negedge, the rising edge samples, check at the following negedge.
    task automatic apply(input string tag, input logic [2:0] i, input logic w,
                         input logic r, input logic [63:0] d, input logic e);
        idx = i; wr = w; rd = r; wd = d; ext = e;
        model_step(i, w, r, d, e);
        @(negedge clk);
        wr = 0; rd = 0;
        compare_all(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset");
        chk("R1 reset ill/gp", {62'd0, ill, gp}, 64'd0);

        // R2: upper bits accepted in address registers
        apply("R2 addr0 full", 3'd0, 1, 0, 64'hDEAD_BEEF_0123_4567, 0);
        apply("R2 addr3 full", 3'd3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        // R3: alias with ext low
        apply("R3 alias stat w", 3'd4, 1, 0, 64'h0000_0000_0000_000F, 0);
        apply("R3 alias ctrl w", 3'd5, 1, 0, 64'h0000_0000_0000_00FF, 0);
        apply("R3 alias stat r", 3'd4, 0, 1, 64'd0, 0);
        chk("R3 rdata is status", rdata, 64'h0000_0000_FFFF_0FFF);
        apply("R3 alias ctrl r", 3'd5, 0, 1, 64'd0, 0);
        chk("R3 rdata is ctrl", rdata, 64'h0000_0000_0000_04FF);
        // R4: illegal with ext high
        apply("R4 ill write", 3'd5, 1, 0, 64'h1, 1);
        chk("R4 ill pulse", {63'd0, ill}, 64'd1);
        apply("R4 ill read", 3'd4, 0, 1, 64'd0, 1);
        chk("R9 ill back-to-back", {63'd0, ill}, 64'd1);
        apply("R9 idle", 3'd0, 0, 0, 64'd0, 0);
        chk("R9 pulse ends", {62'd0, ill, gp}, 64'd0);
        // R5: reserved bits at edges
        apply("R5 bit32 ctrl", 3'd7, 1, 1, 64'h0000_0001_0000_0000, 0);
        chk("R5 gp pulse", {63'd0, gp}, 64'd1);
        apply("R5 bit63 stat", 3'd6, 1, 0, 64'h8000_0000_0000_0000, 1);
        // R9: illegal + reserved => ill only
        apply("R9 priority", 3'd4, 1, 0, 64'hFFFF_0000_0000_0000, 1);
        chk("R9 priority gp low", {63'd0, gp}, 64'd0);
        // R6/R7: fixed ones forced
        apply("R6 stat zero", 3'd6, 1, 0, 64'd0, 1);
        chk("R6 stat fixed", stat, FS);
        apply("R7 ctrl zero", 3'd7, 1, 0, 64'd0, 1);
        chk("R7 ctrl fixed", ctrl, FC);
        // R8: read-before-write
        apply("R8 rw addr1 a", 3'd1, 1, 0, 64'h1111, 0);
        apply("R8 rw addr1 b", 3'd1, 1, 1, 64'h2222, 0);
        chk("R8 old value", rdata, 64'h1111);
        // R10: ext ignored on 0-3,6,7
        apply("R10 ext addr2", 3'd2, 1, 1, 64'h5555_0000_AAAA_0000, 1);
        apply("R10 ext ctrl r", 3'd7, 0, 1, 64'd0, 1);
        chk("R10 ctrl read", rdata, FC);

        for (int n = 0; n < 1500; n++) begin
            d = {$urandom(), $urandom()};
            if ($urandom() % 3 != 0) d[63:32] = '0;
            apply("R3 R10 random", 3'($urandom()), 1'($urandom()), 1'($urandom()),
                  d, 1'($urandom()));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule